// File: doc/BRIEF.md
# Glitch-free two-input clock switch

This block picks one of two unrelated clocks, A or B, and passes it to a clock output without runt pulses or glitches. A single select level chooses the source. When the select moves, the lane that carries the old clock lets a fixed number of its own cycles pass and then shuts. The output then rests low while the lane for the new clock counts its own cycles before it opens. Each lane acts only on signals that have first been synchronized into its own clock domain. Both lanes shut and open their gates only while their clock is low.

An external detector provides one "stopped" flag per input. If the clock that feeds the output is flagged as stopped when the select moves away from it, that lane is cleared at once. The handover then goes ahead without waiting for edges that will never come, and this holds whether the dead clock rests high or low. The switched clock leaves the block on two copies. Each copy has its own enable and floats when its enable is low. An asynchronous active-low reset shuts both lanes. Reset release is resynchronized inside each lane.

Top module: `clk_switch2`

## Requirements
- R1: With the select stable at 1 the output follows input B; at 0 it follows input A, high phase for high phase and low phase for low phase.
- R2: With both clocks running, after the select changes the output passes exactly three more rising edges of the old clock, counted from the first old rising edge after the change. It then goes low at the falling edge of the third.
- R3: Once the old clock is retired, the output stays low across exactly three rising edges of the new clock. The fourth rising edge of the new clock is the first output rising edge.
- R4: If the current clock's stopped flag (stop_a for A, stop_b for B) is high when the select moves away from it, the output goes low in the same instant, and no further old-clock pulse appears. The three-edge low gap of R3 is then counted from the select change.
- R5: A stopped input parked high or parked low is handled alike. While the stopped clock is still selected, the output holds its parked level, and the switch away from it completes without a short pulse.
- R6: No output high or low phase is ever shorter than the shorter input half-period.
- R7: Every output rising edge coincides with a rising edge of an input clock, and the two lanes are never open at the same time.
- R8: Output copy N drives the switched clock when its enable oeN is 1 and is high impedance when oeN is 0.
- R9: While rst_n is low, the output is low. After release it stays low until the selected clock has given at least three rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Input clock A, chosen when sel is 0 |
| clk_b | input | 1 | Input clock B, chosen when sel is 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source select: 0 = A, 1 = B |
| stop_a | input | 1 | High when clock A is known to have stopped |
| stop_b | input | 1 | High when clock B is known to have stopped |
| oe0 | input | 1 | Enable for clk_out0, 0 floats the pin |
| oe1 | input | 1 | Enable for clk_out1, 0 floats the pin |
| clk_out0 | output | 1 | Switched clock, copy 0 |
| clk_out1 | output | 1 | Switched clock, copy 1 |

## Verification
The bench builds the switch with its default depths: two synchronizer stages in each lane and two reset-release stages. This makes the handover exactly three old-clock pulses followed by a three-edge low gap, so both counts can be checked as exact values. The inputs run at 5 ns and 7 ns with a 1.3 ns phase offset, and stops and restarts are quantized to 0.5 ns. Because of this no edge of one clock ever lands on an edge of the other. Every output pulse can therefore be attributed to exactly one source, and switches in both directions are checked, including switches away from a clock parked high and one parked low.

// File: rtl/swc_pkg.sv
`timescale 1ps/1ps
package swc_pkg;
  // number of clock sources handled by the switch
  localparam int NUM_SRC = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/swc_rst_sync.sv
`timescale 1ps/1ps
// Reset bridge: asserts asynchronously, releases on the local clock.
module swc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) pipe_q <= '0;
    else           pipe_q <= pipe_d;
  end

  assign srst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/swc_sync.sv
`timescale 1ps/1ps
// Level synchronizer into the local clock domain.
module swc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swc_lane.sv
`timescale 1ps/1ps
// One source lane: request sync, settle register, low-phase gate.
module swc_lane #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic sel_me_i,
  input  logic stop_i,
  input  logic peer_gate_i,
  output logic gate_o
);
  logic lane_arst_n;
  logic rs_n;
  logic req_raw;
  logic req_s;
  logic on_q;
  logic on_d;
  logic on_en;
  logic gate_q;

  // a stopped lane that is no longer wanted is cleared without its clock
  assign lane_arst_n = arst_n_i & ~(stop_i & ~sel_me_i);

  swc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_n_i(lane_arst_n),
    .srst_n_o(rs_n)
  );

  // open only when chosen and the other lane is shut
  assign req_raw = sel_me_i & ~peer_gate_i;

  swc_sync #(.STAGES(SYNC_STAGES)) u_req (
    .clk_i  (clk_i),
    .rst_n_i(rs_n),
    .d_i    (req_raw),
    .q_o    (req_s)
  );

  always_comb begin
    on_d  = req_s;
    on_en = (on_q != req_s);
  end

  always_ff @(posedge clk_i or negedge rs_n) begin
    if (!rs_n)      on_q <= 1'b0;
    else if (on_en) on_q <= on_d;
  end

  // gate moves only while the clock is low
  always_ff @(negedge clk_i or negedge rs_n) begin
    if (!rs_n) gate_q <= 1'b0;
    else       gate_q <= on_q;
  end

  assign gate_o = gate_q;

  // R7
  excl_chk: assert property (@(posedge clk_i) disable iff (!rs_n)
    gate_q |-> !peer_gate_i)
    else $error("lane open while peer open");

  // R3
  handover_chk: assert property (@(negedge clk_i) disable iff (!rs_n)
    $rose(gate_q) |-> !peer_gate_i)
    else $error("lane opened before peer shut");

  // R2
  deselect_chk: assert property (@(posedge clk_i) disable iff (!rs_n)
    (!sel_me_i && $past(!sel_me_i) && $past(!sel_me_i, 2) && $past(!sel_me_i, 3))
      |-> !gate_q)
    else $error("deselected lane still open");

  // R9
  rst_off_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !rs_n |-> !gate_q)
    else $error("gate open during lane reset");
endmodule

// File: rtl/clk_switch2.sv
`timescale 1ps/1ps
module clk_switch2 #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  input  logic stop_a,
  input  logic stop_b,
  input  logic oe0,
  input  logic oe1,
  output wire  clk_out0,
  output wire  clk_out1
);
  import swc_pkg::*;

  src_vec_t clk_v;
  src_vec_t stop_v;
  src_vec_t sel_me;
  src_vec_t gate_v;
  logic     sw_clk;

  assign clk_v  = {clk_b, clk_a};
  assign stop_v = {stop_b, stop_a};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    assign sel_me[i] = (sel == 1'(i));

    swc_lane #(
      .SYNC_STAGES(SYNC_STAGES),
      .RST_STAGES (RST_STAGES)
    ) u_lane (
      .clk_i      (clk_v[i]),
      .arst_n_i   (rst_n),
      .sel_me_i   (sel_me[i]),
      .stop_i     (stop_v[i]),
      .peer_gate_i(gate_v[NUM_SRC-1-i]),
      .gate_o     (gate_v[i])
    );

    // R4
    stopped_off_chk: assert property (@(posedge clk_v[NUM_SRC-1-i]) disable iff (!rst_n)
      (stop_v[i] && !sel_me[i]) |-> !gate_v[i])
      else $error("stopped, deselected lane still open");
  end

  assign sw_clk = |(clk_v & gate_v);

  assign clk_out0 = oe0 ? sw_clk : 1'bz;
  assign clk_out1 = oe1 ? sw_clk : 1'bz;
endmodule

// File: tb/sim_clk_switch2.sv
`timescale 1ps/1ps
module sim_clk_switch2;
  logic clk_a, clk_b, rst_n, sel, stop_a, stop_b, oe0, oe1;
  wire  clk_out0, clk_out1;

  bit run_a = 1, run_b = 1, park_a = 0, park_b = 0;
  bit mon_on = 0, done = 0;
  int checks = 0, errors = 0;
  longint qa[$], qb[$], qr[$], qf[$];
  logic   prev_o = 1'bx;
  longint last_t = 0;
  bit     have_last = 0;
  longint t7 = 0;

  clk_switch2 u0 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel),
    .stop_a(stop_a), .stop_b(stop_b), .oe0(oe0), .oe1(oe1),
    .clk_out0(clk_out0), .clk_out1(clk_out1)
  );

  // 200 MHz clock A; edges stay on multiples of 500 ps
  initial begin
    clk_a = 0;
    forever begin
      if (run_a) begin clk_a = ~clk_a; #2500; end
      else begin clk_a = park_a; #500; end
    end
  end

  // clock B, 7 ns, offset so its edges never meet those of A
  initial begin
    clk_b = 0;
    #1300;
    forever begin
      if (run_b) begin clk_b = ~clk_b; #3500; end
      else begin clk_b = park_b; #500; end
    end
  end

  always @(posedge clk_a) qa.push_back($time);
  always @(posedge clk_b) qb.push_back($time);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit on_edge(input bit nb, input longint t);
    if (nb) begin foreach (qb[k]) if (qb[k] == t) return 1'b1; end
    else    begin foreach (qa[k]) if (qa[k] == t) return 1'b1; end
    return 1'b0;
  endfunction

  function automatic int edges_between(input bit nb, input longint t1, input longint t2);
    int n = 0;
    if (nb) begin foreach (qb[k]) if (qb[k] > t1 && qb[k] < t2) n++; end
    else    begin foreach (qa[k]) if (qa[k] > t1 && qa[k] < t2) n++; end
    return n;
  endfunction

  // R6: phase width monitor on copy 0
  always @(clk_out0) begin
    if (mon_on && (clk_out0 === 1'b0 || clk_out0 === 1'b1)
        && (prev_o === 1'b0 || prev_o === 1'b1)) begin
      if (have_last)
        check(($time - last_t) >= 2500, "R6", "output phase width", $time - last_t, 2500);
      last_t    = $time;
      have_last = 1;
      if (clk_out0 === 1'b1) qr.push_back($time);
      else                   qf.push_back($time);
    end
    prev_o = clk_out0;
  end

  // R7: each output rise lands on an input rise
  always @(posedge clk_out0) begin
    if (mon_on && clk_out0 === 1'b1) begin
      t7 = $time;
      #1;
      check(on_edge(1'b0, t7) || on_edge(1'b1, t7), "R7", "output rise on input rise", 0, 1);
    end
  end

  // R2/R3/R4 analysis of one handover from the recorded edges
  task automatic analyze(input longint t0, input bit nb, input int exp_old, input string r_old);
    longint t_new = -1;
    longint low_start;
    int n_old = 0;
    int gap;
    foreach (qr[k]) if (qr[k] > t0 && t_new < 0 && on_edge(nb, qr[k])) t_new = qr[k];
    check(t_new > 0, "R3", "new clock reaches output", longint'(t_new > 0), 1);
    if (t_new > 0) begin
      foreach (qr[k]) if (qr[k] > t0 && qr[k] < t_new && on_edge(!nb, qr[k])) n_old++;
      check(n_old == exp_old, r_old, "old-clock pulses after select change", n_old, exp_old);
      low_start = t0;
      foreach (qf[k]) if (qf[k] < t_new && qf[k] > low_start) low_start = qf[k];
      gap = edges_between(nb, low_start, t_new);
      check(gap == 3, "R3", "new-clock rising edges inside low gap", gap, 3);
    end
  endtask

  // R1: steady output follows the chosen clock
  task automatic steady(input bit nb);
    repeat (3) begin
      if (nb) @(posedge clk_b); else @(posedge clk_a);
      #200;
      check(clk_out0 === 1'b1, "R1", "output high in source high phase", longint'(clk_out0), 1);
      if (nb) @(negedge clk_b); else @(negedge clk_a);
      #200;
      check(clk_out0 === 1'b0, "R1", "output low in source low phase", longint'(clk_out0), 0);
    end
  endtask

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #5000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      finish_sim();
    end
  end

  initial begin
    longint t0, t_rel, t_first;
    int n;
    rst_n = 0; sel = 0; stop_a = 0; stop_b = 0; oe0 = 1; oe1 = 1;
    mon_on = 1;
    #3000;
    check(clk_out0 === 1'b0, "R9", "output low in reset", longint'(clk_out0), 0);
    #9100;
    rst_n = 1;
    t_rel = $time;
    #100000;
    t_first = -1;
    foreach (qr[k]) if (qr[k] > t_rel && t_first < 0) t_first = qr[k];
    check(t_first > 0 && on_edge(1'b0, t_first), "R9", "first output rise from clock A",
          longint'(t_first > 0), 1);
    n = edges_between(1'b0, t_rel, t_first);
    check(n >= 3, "R9", "clock A edges before first output rise", n, 3);
    steady(1'b0);

    // running A -> running B
    @(posedge clk_a); #1100;
    sel = 1; t0 = $time;
    #80000;
    analyze(t0, 1'b1, 3, "R2");
    steady(1'b1);

    // running B -> running A
    @(posedge clk_b); #1100;
    sel = 0; t0 = $time;
    #80000;
    analyze(t0, 1'b0, 3, "R2");
    steady(1'b0);

    // R8: copy 1 enable
    oe1 = 0;
    #1000;
    check(clk_out1 === 1'bz, "R8", "copy 1 floats when disabled", longint'(clk_out1 === 1'bz), 1);
    oe1 = 1;
    repeat (3) begin
      @(posedge clk_a); #200;
      check(clk_out1 === 1'b1 && clk_out1 === clk_out0, "R8", "copy 1 drives switched clock",
            longint'(clk_out1), 1);
    end

    // R4/R5: A parked high while selected, then flagged and left
    @(posedge clk_a);
    run_a = 0; park_a = 1;
    #20100;
    check(clk_out0 === 1'b1, "R5", "output holds parked-high level", longint'(clk_out0), 1);
    stop_a = 1;
    #1000;
    sel = 1; t0 = $time;
    #10;
    check(clk_out0 === 1'b0, "R4", "output drops at once on select change", longint'(clk_out0), 0);
    #80000;
    analyze(t0, 1'b1, 0, "R4");
    steady(1'b1);

    // restart A, then a running switch back to it
    #100;
    run_a = 1; stop_a = 0;
    #40000;
    @(posedge clk_b); #1100;
    sel = 0; t0 = $time;
    #80000;
    analyze(t0, 1'b0, 3, "R2");
    steady(1'b0);

    // R5: A parked low while selected, then flagged and left
    @(negedge clk_a);
    run_a = 0; park_a = 0;
    #20100;
    check(clk_out0 === 1'b0, "R5", "output holds parked-low level", longint'(clk_out0), 0);
    stop_a = 1;
    #1000;
    sel = 1; t0 = $time;
    #10;
    check(clk_out0 === 1'b0, "R5", "output low after leaving parked-low clock", longint'(clk_out0), 0);
    #80000;
    analyze(t0, 1'b1, 0, "R5");
    steady(1'b1);

    // R8: copy 0 enable
    mon_on = 0;
    #100;
    oe0 = 0;
    #1000;
    check(clk_out0 === 1'bz, "R8", "copy 0 floats when disabled", longint'(clk_out0 === 1'bz), 1);
    oe0 = 1;
    #1000;
    finish_sim();
  end
endmodule